// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This unit collects single-cycle event pulses from the engines of a multi-channel DMA controller and turns them into one interrupt line. Each channel owns a 22-bit event vector. Two completion events sit at positions 0 and 1, and error events sit at positions 5 to 14 and 16 to 21. The other positions are not implemented. Software sets two masks for each channel. The capture mask decides whether a pulse is recorded in the channel's sticky status word at all. The signal mask decides whether a recorded bit takes part in raising the interrupt. Status bits are removed by writing ones to a clear register.

A common pending word shows which channels hold at least one recorded bit that is also signal-enabled. Software reads it and services the lowest set channel first. A two-bit global control word holds a controller enable, which is driven out to the engines, and a global interrupt enable. A two-state machine registers the interrupt line. It moves from `IRQ_IDLE` to `IRQ_ACTIVE` when the interrupt enable is set and some channel is pending. It moves from `IRQ_ACTIVE` back to `IRQ_IDLE` as soon as that condition no longer holds.

The register port is a simple one. A write takes effect at a clock edge when `wr_en` is high. Reads are combinational from the registered state.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every capture mask, signal mask, status word, the control word and the pending word read 0, and `irq` and `dma_en` are low.
- R2: An event pulse on a channel's bit sets that status bit at the clock edge only if the bit is set in that channel's capture mask. A pulse on a bit whose capture mask bit is 0 leaves the status bit at 0.
- R3: A status bit whose signal-mask bit is 0 contributes neither to that channel's pending bit nor to `irq`.
- R4: Writing the clear register clears exactly the status bits written as 1. Bits written as 0 keep their value.
- R5: When an enabled event pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R6: Only bit positions 0, 1, 5 to 14 and 16 to 21 are implemented. At every other position, events are never recorded and the capture and signal masks read back 0 whatever was written.
- R7: Bit n of the pending word is 1 exactly when channel n has some bit set in both its status word and its signal mask. Bits above the channel count read 0.
- R8: Bit 0 of the control word drives `dma_en`. Bit 1 is the global interrupt enable. Both read back as written.
- R9: `irq` is high in the cycle after one in which the interrupt enable is set and some pending bit is 1. It is low in the cycle after any other cycle.
- R10: With the global interrupt enable at 0, `irq` is low from the next cycle on, and recorded status is kept.
- R11: Address map, with `AW = clog2(NCH)+3`. A channel register is at `{0, channel, sel}`, where sel 0 is the capture mask, 1 is status (read only: writes are ignored), 2 is the signal mask and 3 is clear (write only, reads 0). With the top address bit set, address bit 0 = 0 selects the control word and bit 0 = 1 selects the pending word.
- R12: A recorded status bit stays set across idle cycles until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NCH*22 | Event pulses, channel n at bits [n*22 +: 22] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 22 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 22 | Read data, combinational |
| dma_en | output | 1 | Controller enable (control bit 0) |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the unit with two channels, which gives a 4-bit address space and a 44-bit event bus. This is small enough to sweep all 22 bit positions on both channels. Each sweep step pulses the enabled bit together with an unenabled neighbour and a same-position pulse on the other channel. Two channels are enough to show channel isolation, a pending word with both bits set, and every decode of the address map. Directed cases cover the event-versus-clear collision, the signal mask, the interrupt gate and the one-cycle interrupt latency.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned STAT_W = 22;

    typedef enum logic [1:0] {
        SEL_CAPT  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_SIGM  = 2'd2,
        SEL_CLEAR = 2'd3
    } chan_sel_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    // Implemented positions: completion pair and two error ranges.
    function automatic logic [STAT_W-1:0] impl_bits();
        logic [STAT_W-1:0] m;
        for (int i = 0; i < int'(STAT_W); i++) begin
            m[i] = (i <= 1) || (i >= 5 && i <= 14) || (i >= 16 && i <= 21);
        end
        return m;
    endfunction

    localparam logic [STAT_W-1:0] IMPL_MASK = impl_bits();

endpackage

// File: rtl/irq_chan_regs.sv
module irq_chan_regs
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt,
    input  logic              capt_we,
    input  logic              sigm_we,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] capt_q,
    output logic [STAT_W-1:0] sigm_q,
    output logic [STAT_W-1:0] stat_q,
    output logic              pend
);

    logic [STAT_W-1:0] clr_bits;
    logic [STAT_W-1:0] set_bits;

    always_comb begin
        clr_bits = clr_we ? wdata : '0;
        set_bits = evt & capt_q & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capt_q <= '0;
            sigm_q <= '0;
            stat_q <= '0;
        end else begin
            if (capt_we) capt_q <= wdata & IMPL_MASK;
            if (sigm_we) sigm_q <= wdata & IMPL_MASK;
            // set term applied after clear: a colliding event survives
            stat_q <= (stat_q & ~clr_bits) | set_bits;
        end
    end

    assign pend = |(stat_q & sigm_q);

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    output logic irq
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (raise)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!raise) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_ACTIVE);
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter  int unsigned NCH  = 4,
    localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned AW   = CH_W + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH*STAT_W-1:0] evt_i,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [STAT_W-1:0]     wr_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [STAT_W-1:0]     rd_data,
    output logic                  dma_en,
    output logic                  irq
);

    logic [1:0]            ctrl_q;
    logic                  int_en;
    logic [NCH-1:0]        pend_vec;
    logic [NCH*STAT_W-1:0] capt_all;
    logic [NCH*STAT_W-1:0] sigm_all;
    logic [NCH*STAT_W-1:0] stat_all;

    logic                  wr_chan;
    logic [CH_W-1:0]       wr_ch;
    chan_sel_e             wr_sel;

    always_comb begin
        wr_chan = wr_en && !wr_addr[AW-1];
        wr_ch   = wr_addr[AW-2:2];
        wr_sel  = chan_sel_e'(wr_addr[1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr[AW-1] && !wr_addr[0]) begin
            ctrl_q <= wr_data[1:0];
        end
    end

    assign dma_en = ctrl_q[0];
    assign int_en = ctrl_q[1];

    for (genvar g = 0; g < int'(NCH); g++) begin : g_chan
        logic hit;
        assign hit = wr_chan && (wr_ch == CH_W'(g));

        irq_chan_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_i[g*STAT_W +: STAT_W]),
            .capt_we (hit && (wr_sel == SEL_CAPT)),
            .sigm_we (hit && (wr_sel == SEL_SIGM)),
            .clr_we  (hit && (wr_sel == SEL_CLEAR)),
            .wdata   (wr_data),
            .capt_q  (capt_all[g*STAT_W +: STAT_W]),
            .sigm_q  (sigm_all[g*STAT_W +: STAT_W]),
            .stat_q  (stat_all[g*STAT_W +: STAT_W]),
            .pend    (pend_vec[g])
        );
    end

    irq_line_fsm u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (int_en && (|pend_vec)),
        .irq   (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr[AW-1]) begin
            if (rd_addr[0]) rd_data[NCH-1:0] = pend_vec;
            else            rd_data[1:0]     = ctrl_q;
        end else begin
            for (int i = 0; i < int'(NCH); i++) begin
                if (rd_addr[AW-2:2] == CH_W'(i)) begin
                    unique case (chan_sel_e'(rd_addr[1:0]))
                        SEL_CAPT:  rd_data = capt_all[i*STAT_W +: STAT_W];
                        SEL_STAT:  rd_data = stat_all[i*STAT_W +: STAT_W];
                        SEL_SIGM:  rd_data = sigm_all[i*STAT_W +: STAT_W];
                        SEL_CLEAR: rd_data = '0;
                        default:   rd_data = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter  int unsigned NCH  = 4,
    localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned AW   = CH_W + 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH*STAT_W-1:0] evt_i,
    input logic                  wr_en,
    input logic [AW-1:0]         wr_addr,
    input logic [STAT_W-1:0]     wr_data,
    input logic                  irq,
    input logic                  int_en,
    input logic [NCH*STAT_W-1:0] capt_all,
    input logic [NCH*STAT_W-1:0] sigm_all,
    input logic [NCH*STAT_W-1:0] stat_all
);

    logic [NCH*STAT_W-1:0] clr_flat;
    logic [NCH*STAT_W-1:0] full_mask;

    for (genvar g = 0; g < int'(NCH); g++) begin : g_c
        assign clr_flat[g*STAT_W +: STAT_W] =
            (wr_en && wr_addr == {1'b0, CH_W'(g), 2'b11}) ? wr_data : '0;
        assign full_mask[g*STAT_W +: STAT_W] = IMPL_MASK;
    end

    assert_no_unimpl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_all & ~full_mask) == '0);

    assert_gated_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_all & ~$past(stat_all) & ~$past(evt_i & capt_all)) == '0));

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_i & capt_all) & ~stat_all) == '0));

    assert_w1c_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_all) & ~stat_all & ~$past(clr_flat)) == '0));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> !irq);

    assert_irq_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(int_en && ((stat_all & sigm_all) != '0))));

endmodule

bind irq_aggregator irq_aggregator_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq      (irq),
    .int_en   (int_en),
    .capt_all (capt_all),
    .sigm_all (sigm_all),
    .stat_all (stat_all)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;

    localparam int NCH = 2;
    localparam int SW  = 22;
    localparam int AW  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*SW-1:0] evt_i = '0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [SW-1:0]     wr_data = '0;
    logic [AW-1:0]     rd_addr = '0;
    logic [SW-1:0]     rd_data;
    logic              dma_en;
    logic              irq;

    int checks = 0;
    int failures = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;

    logic [SW-1:0] m_capt [NCH];
    logic [SW-1:0] m_sigm [NCH];
    logic [SW-1:0] m_stat [NCH];
    logic [1:0]    m_ctrl;

    always #2 clk = ~clk;

    irq_aggregator #(.NCH(NCH)) u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .dma_en(dma_en), .irq(irq)
    );

    function automatic logic [SW-1:0] valid_bits();
        logic [SW-1:0] m;
        for (int i = 0; i < SW; i++) m[i] = (i < 2) || (i > 4 && i < 15) || (i > 15);
        return m;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [SW-1:0] act, input logic [SW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input string what,
                          input logic [AW-1:0] a, input logic [SW-1:0] exp);
        rd_addr = a;
        #0.5;
        check(tag, what, rd_data, exp);
    endtask

    function automatic logic [SW-1:0] exp_pend();
        logic [SW-1:0] p = '0;
        for (int c = 0; c < NCH; c++) p[c] = |(m_stat[c] & m_sigm[c]);
        return p;
    endfunction

    task automatic chk_all(input string tag);
        for (int c = 0; c < NCH; c++) begin
            chk_rd(tag, "capture", AW'(c*4+0), m_capt[c]);
            chk_rd(tag, "status",  AW'(c*4+1), m_stat[c]);
            chk_rd(tag, "sigmask", AW'(c*4+2), m_sigm[c]);
            chk_rd(tag, "clear-rd", AW'(c*4+3), '0);
        end
        chk_rd(tag, "control", 4'd8, {20'd0, m_ctrl});
        chk_rd(tag, "pending", 4'd9, exp_pend());
    endtask

    // one clock: inputs driven at a falling edge, released at the next
    task automatic cyc(input logic [NCH*SW-1:0] evt, input logic we,
                       input logic [AW-1:0] a, input logic [SW-1:0] d);
        logic [SW-1:0] clr;
        logic [SW-1:0] ns;
        evt_i = evt; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        for (int c = 0; c < NCH; c++) begin
            clr = (we && a == AW'(c*4+3)) ? d : '0;
            ns  = (m_stat[c] & ~clr) | (evt[c*SW +: SW] & m_capt[c] & valid_bits());
            if (we && a == AW'(c*4+0)) m_capt[c] = d & valid_bits();
            if (we && a == AW'(c*4+2)) m_sigm[c] = d & valid_bits();
            m_stat[c] = ns;
        end
        if (we && a == 4'd8) m_ctrl = d[1:0];
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [SW-1:0] d);
        cyc('0, 1'b1, a, d);
    endtask

    task automatic idle();
        cyc('0, 1'b0, '0, '0);
    endtask

    function automatic logic exp_irq();
        return m_ctrl[1] && (exp_pend() != '0);
    endfunction

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000 && !done) begin
            failures++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NCH*SW-1:0] ev;
        for (int c = 0; c < NCH; c++) begin
            m_capt[c] = '0; m_sigm[c] = '0; m_stat[c] = '0;
        end
        m_ctrl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_all("R1");
        check("R1", "irq", {21'd0, irq}, '0);
        check("R1", "dma_en", {21'd0, dma_en}, '0);

        // R8 control word
        wr(4'd8, 22'h1);
        check("R8", "dma_en", {21'd0, dma_en}, 22'h1);
        chk_rd("R8", "control", 4'd8, 22'h1);
        wr(4'd8, 22'h3);
        chk_all("R8");

        // sweep over both channels and all bit positions (R2 R3 R4 R6 R9)
        for (int c = 0; c < NCH; c++) begin
            for (int b = 0; b < SW; b++) begin
                int oth;
                oth = (b == SW-1) ? 0 : b + 1;
                for (int k = 0; k < NCH; k++) begin
                    wr(AW'(k*4+0), '0);
                    wr(AW'(k*4+2), '0);
                    wr(AW'(k*4+3), '1);
                end
                wr(AW'(c*4+0), SW'(1) << b);
                wr(AW'(c*4+2), SW'(1) << b);
                chk_all("R6");
                ev = '0;
                ev[c*SW + b] = 1'b1;
                ev[c*SW + oth] = 1'b1;
                ev[(1-c)*SW + b] = 1'b1;
                cyc(ev, 1'b0, '0, '0);
                check("R9", "irq before latency", {21'd0, irq}, '0);
                idle();
                chk_all("R2");
                check("R3", "irq after event", {21'd0, irq}, {21'd0, exp_irq()});
                wr(AW'(c*4+3), '0);
                chk_all("R4");
                wr(AW'(c*4+3), SW'(1) << b);
                idle();
                chk_all("R4");
                check("R9", "irq after clear", {21'd0, irq}, '0);
            end
        end

        // R5 collision of event and clear
        wr(4'd0, 22'h1);
        wr(4'd2, 22'h1);
        cyc({22'd0, 22'h1}, 1'b0, '0, '0);
        cyc({22'd0, 22'h1}, 1'b1, 4'd3, 22'h1);
        chk_all("R5");
        check("R5", "status bit0", rd_data & 22'h0, 22'h0);
        chk_rd("R5", "status kept", 4'd1, 22'h1);

        // R12 sticky across idle cycles
        repeat (5) idle();
        chk_rd("R12", "status sticky", 4'd1, 22'h1);
        check("R12", "irq held", {21'd0, irq}, 22'h1);

        // R3 signal mask off
        wr(4'd2, 22'h0);
        idle();
        chk_all("R3");
        check("R3", "irq masked", {21'd0, irq}, '0);

        // R10 global interrupt gate
        wr(4'd2, 22'h1);
        idle();
        check("R10", "irq on", {21'd0, irq}, 22'h1);
        wr(4'd8, 22'h1);
        idle();
        check("R10", "irq gated", {21'd0, irq}, '0);
        chk_all("R10");

        // R11 writes to status address ignored
        wr(4'd1, 22'h3FFFFF);
        chk_all("R11");
        wr(4'd5, 22'h3FFFFF);
        chk_rd("R11", "ch1 status write ignored", 4'd5, '0);

        // R7 both channels pending
        wr(4'd8, 22'h3);
        wr(4'd4, 22'h20);
        wr(4'd6, 22'h20);
        cyc({22'h20, 22'h0}, 1'b0, '0, '0);
        idle();
        chk_rd("R7", "pending both", 4'd9, 22'h3);
        chk_all("R7");
        check("R7", "irq", {21'd0, irq}, 22'h1);
        wr(4'd3, 22'h1);
        chk_rd("R7", "pending ch1 only", 4'd9, 22'h2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule